// File: doc/BRIEF.md
# Delta-Sigma Converter Cycle Sequencer

This block is the digital control side of a zero-latency delta-sigma converter. It runs one fixed cycle over and over. First it converts for a fixed number of conversion-clock ticks. Then it sleeps and keeps the captured result for as long as the host holds chip select high. Last, it shifts a 32-bit frame out on the serial data line, driven by a host serial clock. The block leaves the analog modulator and the filter arithmetic out. The result word arrives on a parallel port, and the block captures it in the cycle in which the conversion ends.

The conversion clock comes from one frequency-select pin. If that pin holds a static level, an internal divider of the system clock produces ticks. The pin's level picks one of two divide ratios: high gives the slower 50 Hz notch rate and low gives the faster 60 Hz rate. If the pin toggles, the block detects an external clock and counts each rising edge of the pin as one tick.

The host starts a readout by pulling chip select low after a conversion. Each new bit appears after a falling serial-clock edge, so the host samples on the rising edge. A readout ends in one of two ways: after 32 falling edges, or when chip select rises early. Either way a new conversion starts at once. While a conversion runs and chip select is low, the data line carries a busy status, so the host can poll for completion. All pins are synchronised to the system clock.

Top module: `conv_cycle_seq`

## Requirements
- R1: A conversion lasts CONV_CYCLES conversion ticks. In level mode one tick takes DIV_LO system-clock cycles when fsel is low and DIV_HI cycles when fsel is high. The first conversion starts when reset is released.
- R2: If fsel shows at least two rising edges inside one window of DET_WIN system-clock cycles, each later rising edge of fsel counts as one tick. If a window holds fewer than two rising edges, the block returns to level mode.
- R3: At the end of a conversion, conv_done pulses high for exactly one cycle. The block captures res_data, res_sign and res_ovr in that cycle and then sleeps while cs_n is high. The captured word does not change during sleep, even if the result inputs change.
- R4: The frame is sent most significant bit first. Its bits, in order, are: end-of-conversion (0 = data ready), a zero, res_sign, res_ovr, res_data from bit 23 down to bit 0, and then four zeros. The first bit appears when cs_n falls. Each later bit appears after a falling edge of sck.
- R5: The 32nd falling edge of sck ends the readout and starts a new conversion at once. That conversion captures a fresh result.
- R6: A rise of cs_n during readout aborts the transfer at once and starts a new conversion. The next readout carries that new conversion's result.
- R7: While cs_n is high, sdo_oe is low and sdo is 0.
- R8: While cs_n is low, sdo is 1 during a conversion (busy). It changes to 0 (ready) as soon as the conversion completes.
- R9: During reset, sdo_oe, sdo and conv_done are all low.
- R10: sck edges while cs_n is high do not change the frame. A later readout still begins with the first frame bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsel | input | 1 | Frequency select: a static level or an external conversion clock |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Host serial clock for readout |
| res_data | input | 24 | Conversion result, captured when a conversion ends |
| res_sign | input | 1 | Sign bit of the result |
| res_ovr | input | 1 | Extended-range flag of the result |
| sdo | output | 1 | Serial data or status; 0 when not enabled |
| sdo_oe | output | 1 | Output enable for sdo |
| conv_done | output | 1 | One-cycle pulse when a conversion ends |

## Verification
Conversion length is measured three ways: with fsel low, with fsel high, and with fsel toggling. This separates the two divide ratios from external-clock counting, and a final level run shows that detection falls back. Readouts use results with different sign, range and data patterns. The bench compares full frames and also an aborted partial frame, which catches wrong bit order, a missing capture or a stale result. Serial-clock edges sent during sleep and result changes made during sleep check that the held frame stays untouched. Polling with cs_n held low checks the busy-to-ready status change.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_SHIFT = 2'd2
    } ccs_state_e;

    localparam int CCS_HDR_W = 4;  // ready flag, zero, sign, range flag

endpackage

// File: rtl/ccs_sync.sv
module ccs_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    assign stg_d[0] = din;

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign stg_d[g] = stg_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/ccs_clk_sel.sv
module ccs_clk_sel #(
    parameter int DIV_HI  = 6,
    parameter int DIV_LO  = 5,
    parameter int DET_WIN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsel_s,
    output logic tick
);

    localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
    localparam int DW      = $clog2(DIV_MAX) + 1;
    localparam int WW      = $clog2(DET_WIN) + 1;

    typedef struct packed {
        logic [DW-1:0] div_cnt;
        logic [WW-1:0] win_cnt;
        logic [1:0]    edges;
        logic          prev;
        logic          ext;
    } sel_regs_t;

    sel_regs_t q, d;
    logic      rise;
    logic      int_tick;

    always_comb begin
        logic [DW-1:0] lim;
        logic [1:0]    edges_nx;
        d        = q;
        rise     = fsel_s & ~q.prev;
        d.prev   = fsel_s;
        lim      = fsel_s ? DW'(DIV_HI - 1) : DW'(DIV_LO - 1);
        int_tick = (q.div_cnt >= lim);
        d.div_cnt = int_tick ? '0 : q.div_cnt + 1'b1;
        edges_nx = (rise && q.edges != 2'd2) ? q.edges + 2'd1 : q.edges;
        if (q.win_cnt == WW'(DET_WIN - 1)) begin
            d.win_cnt = '0;
            d.ext     = (edges_nx == 2'd2);
            d.edges   = '0;
        end else begin
            d.win_cnt = q.win_cnt + 1'b1;
            d.edges   = edges_nx;
        end
        tick = q.ext ? rise : int_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: the mode only changes at a window boundary
    a_r2_mode_at_window: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.ext) |-> (q.win_cnt == '0));

    // R1: the divider never passes the larger ratio
    a_r1_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.div_cnt <= DW'(DIV_MAX));

endmodule

// File: rtl/ccs_conv_timer.sv
module ccs_conv_timer #(
    parameter int CONV_CYCLES = 20480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    output logic done
);

    localparam int CW = $clog2(CONV_CYCLES) + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
        logic          done;
    } tm_regs_t;

    tm_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (restart) begin
            d.cnt = '0;
            d.run = 1'b1;
        end else if (q.run && tick) begin
            if (q.cnt == CW'(CONV_CYCLES - 1)) begin
                d.cnt  = '0;
                d.run  = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, run: 1'b1, done: 1'b0};
        else        q <= d;
    end

    assign done = q.done;

    // R3: conv_done is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R1: the tick count stays inside one conversion
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CW'(CONV_CYCLES));

    // R1: an idle timer waits for a restart
    a_r1_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.run && !restart) |=> !q.run);

endmodule

// File: rtl/ccs_shifter.sv
module ccs_shifter #(
    parameter int RES_W   = 24,
    parameter int FRAME_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_sign,
    input  logic             res_ovr,
    output logic             msb,
    output logic             last
);

    import ccs_pkg::*;

    localparam int BW  = $clog2(FRAME_W);
    localparam int PAD = FRAME_W - RES_W - CCS_HDR_W;

    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic [BW-1:0]      bcnt;
    } sh_regs_t;

    sh_regs_t           q, d;
    logic [FRAME_W-1:0] frame;

    if (PAD > 0) begin : g_pad
        assign frame = {2'b00, res_sign, res_ovr, res_data, {PAD{1'b0}}};
    end else begin : g_nopad
        assign frame = {2'b00, res_sign, res_ovr, res_data};
    end

    always_comb begin
        d = q;
        if (load) begin
            d.sreg = frame;
            d.bcnt = '0;
        end else if (shift) begin
            d.sreg = {q.sreg[FRAME_W-2:0], 1'b0};
            d.bcnt = q.bcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign msb  = q.sreg[FRAME_W-1];
    assign last = (q.bcnt == BW'(FRAME_W - 1));

    // R3: the held frame changes only on a load or a shift
    a_r3_hold_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(q.sreg));

    // R4: a shift never happens past the final bit
    a_r4_no_overshift: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last);

endmodule

// File: rtl/conv_cycle_seq.sv
module conv_cycle_seq #(
    parameter int CONV_CYCLES = 20480,
    parameter int DIV_HI      = 6,
    parameter int DIV_LO      = 5,
    parameter int DET_WIN     = 256,
    parameter int SYNC_STAGES = 2,
    parameter int RES_W       = 24,
    parameter int FRAME_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsel,
    input  logic             cs_n,
    input  logic             sck,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_sign,
    input  logic             res_ovr,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             conv_done
);

    import ccs_pkg::*;

    typedef struct packed {
        ccs_state_e state;
        logic       oe;
        logic       sck_prev;
    } top_regs_t;

    top_regs_t q, d;

    logic fsel_s, cs_s, sck_s;
    logic tick, tm_done, restart, load, shift, msb, last, sck_fall;

    ccs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({fsel, cs_n, sck}),
        .dout ({fsel_s, cs_s, sck_s})
    );

    ccs_clk_sel #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO), .DET_WIN(DET_WIN)) u_clk_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .fsel_s(fsel_s),
        .tick  (tick)
    );

    ccs_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .tick   (tick),
        .done   (tm_done)
    );

    ccs_shifter #(.RES_W(RES_W), .FRAME_W(FRAME_W)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (shift),
        .res_data(res_data),
        .res_sign(res_sign),
        .res_ovr (res_ovr),
        .msb     (msb),
        .last    (last)
    );

    always_comb begin
        d          = q;
        restart    = 1'b0;
        load       = 1'b0;
        shift      = 1'b0;
        sck_fall   = q.sck_prev & ~sck_s;
        d.sck_prev = sck_s;
        d.oe       = ~cs_s;
        unique case (q.state)
            ST_CONV: begin
                if (tm_done) begin
                    load    = 1'b1;
                    d.state = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (!cs_s) d.state = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_s) begin
                    restart = 1'b1;
                    d.state = ST_CONV;
                end else if (sck_fall) begin
                    if (last) begin
                        restart = 1'b1;
                        d.state = ST_CONV;
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
            default: d.state = ST_CONV;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_CONV, oe: 1'b0, sck_prev: 1'b0};
        else        q <= d;
    end

    assign sdo_oe    = q.oe;
    assign sdo       = q.oe & ((q.state == ST_SHIFT) ? msb : (q.state == ST_CONV));
    assign conv_done = tm_done;

    // R6: a chip-select rise during readout returns to conversion
    a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SHIFT && cs_s) |=> (q.state == ST_CONV));

    // R5: the final falling edge ends the frame
    a_r5_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SHIFT && !cs_s && sck_fall && last) |=> (q.state == ST_CONV));

    // R3: sleep holds while chip select is high
    a_r3_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SLEEP && cs_s) |=> (q.state == ST_SLEEP));

    // R7: a deselected chip releases the line
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !sdo_oe);

    // R7: no data is driven while the output is disabled
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

endmodule

// File: tb/conv_cycle_seq_bench.sv
module conv_cycle_seq_bench;

    localparam int N    = 64;
    localparam int DLO  = 5;
    localparam int DHI  = 6;
    localparam int WIN  = 64;
    localparam int EXTP = 8;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, sck, fsel_lvl, tog_en, tog_q;
    logic [23:0] res_data;
    logic        res_sign, res_ovr;
    logic        fsel, sdo, sdo_oe, conv_done;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [31:0] exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign fsel = tog_en ? tog_q : fsel_lvl;

    initial begin
        tog_q = 1'b0;
        forever begin
            repeat (EXTP / 2) @(negedge clk);
            tog_q = ~tog_q;
        end
    end

    conv_cycle_seq #(
        .CONV_CYCLES(N), .DIV_HI(DHI), .DIV_LO(DLO), .DET_WIN(WIN),
        .SYNC_STAGES(2), .RES_W(24), .FRAME_W(32)
    ) u_conv_cycle_seq (
        .clk(clk), .rst_n(rst_n), .fsel(fsel), .cs_n(cs_n), .sck(sck),
        .res_data(res_data), .res_sign(res_sign), .res_ovr(res_ovr),
        .sdo(sdo), .sdo_oe(sdo_oe), .conv_done(conv_done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] frame_of(input logic [23:0] dv, input logic s,
                                             input logic o);
        return {2'b00, s, o, dv, 4'h0};
    endfunction

    task automatic set_res(input logic [23:0] dv, input logic s, input logic o);
        res_data = dv;
        res_sign = s;
        res_ovr  = o;
        exp_q.push_back(frame_of(dv, s, o));
    endtask

    task automatic sb_compare(input logic [31:0] got, input logic [31:0] mask,
                              input string tag);
        logic [31:0] e;
        if (exp_q.size() == 0) begin
            check(1'b0, {tag, " queue empty"}, got, 32'h0);
        end else begin
            e = exp_q.pop_front();
            check((got & mask) == (e & mask), tag, got & mask, e & mask);
        end
    endtask

    task automatic read_bits(input int n, output logic [31:0] w);
        w = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sck = 1'b1;
            repeat (8) @(posedge clk);
            @(negedge clk) w[31-i] = sdo;
            sck = 1'b0;
            repeat (8) @(posedge clk);
        end
    endtask

    task automatic wait_done(output int t);
        int k;
        for (k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (conv_done) break;
        end
        if (k == 20000) check(1'b0, "R1 conv_done timeout", 32'h0, 32'h1);
        t = cyc;
    endtask

    task automatic abort_after(input int n, output logic [31:0] w);
        @(negedge clk) cs_n = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk) check(sdo_oe == 1'b1, "R7 oe with cs low", 32'(sdo_oe), 32'h1);
        read_bits(n, w);
        @(negedge clk) cs_n = 1'b1;
    endtask

    task automatic check_len(input int dt, input int per, input string tag);
        check(dt >= N * per - 2 && dt <= N * per + per + 8, tag, 32'(dt), 32'(N * per));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w;
        int t0, t1;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; fsel_lvl = 1'b0; tog_en = 1'b0;
        res_data = '0; res_sign = 1'b0; res_ovr = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check(sdo_oe == 1'b0, "R9 oe in reset", 32'(sdo_oe), 32'h0);
        check(sdo == 1'b0, "R9 sdo in reset", 32'(sdo), 32'h0);
        check(conv_done == 1'b0, "R9 done in reset", 32'(conv_done), 32'h0);
        set_res(24'hA5C3F0, 1'b1, 1'b0);
        rst_n = 1'b1;
        t0 = cyc;
        wait_done(t1);
        check_len(t1 - t0, DLO, "R1 length fsel low");

        // sleep: sck noise and result change must not disturb the held frame
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) sck = 1'b1;
            repeat (4) @(posedge clk);
            @(negedge clk) sck = 1'b0;
            repeat (4) @(posedge clk);
        end
        res_data = 24'h0F1E2D; res_sign = 1'b0; res_ovr = 1'b1;
        repeat (50) @(posedge clk);
        @(negedge clk);
        check(sdo_oe == 1'b0 && sdo == 1'b0, "R7 released in sleep", {sdo_oe, sdo}, 32'h0);

        @(negedge clk) cs_n = 1'b0;
        repeat (10) @(posedge clk);
        @(negedge clk) check(sdo == 1'b0, "R8 ready when result held", 32'(sdo), 32'h0);
        read_bits(32, w);
        sb_compare(w, 32'hFFFF_FFFF, "R4 R3 R10 full frame");

        // cs held low: busy, then ready, then second frame
        set_res(24'h0F1E2D, 1'b0, 1'b1);
        repeat (6) @(posedge clk);
        @(negedge clk) check(sdo == 1'b1, "R8 R5 busy after frame", 32'(sdo), 32'h1);
        wait_done(t1);
        repeat (6) @(posedge clk);
        @(negedge clk) check(sdo == 1'b0, "R8 ready after poll", 32'(sdo), 32'h0);
        read_bits(32, w);
        sb_compare(w, 32'hFFFF_FFFF, "R5 fresh result frame");
        @(negedge clk) cs_n = 1'b1;

        // fsel high, partial read then abort
        fsel_lvl = 1'b1;
        set_res(24'h800001, 1'b1, 1'b1);
        wait_done(t1);
        abort_after(10, w);
        sb_compare(w, 32'hFFC0_0000, "R6 partial frame");
        t0 = cyc;
        set_res(24'h123456, 1'b0, 1'b0);
        repeat (6) @(posedge clk);
        @(negedge clk) check(sdo_oe == 1'b0, "R7 released after abort", 32'(sdo_oe), 32'h0);
        wait_done(t1);
        check_len(t1 - t0, DHI, "R1 length fsel high");
        @(negedge clk) cs_n = 1'b0;
        repeat (10) @(posedge clk);
        read_bits(32, w);
        sb_compare(w, 32'hFFFF_FFFF, "R6 new result after abort");
        @(negedge clk) cs_n = 1'b1;

        // external clock on fsel
        tog_en = 1'b1;
        wait_done(t1);
        repeat (20) @(posedge clk);
        abort_after(0, w);
        t0 = cyc;
        wait_done(t1);
        check_len(t1 - t0, EXTP, "R2 length external clock");

        // back to a static level
        tog_en = 1'b0;
        fsel_lvl = 1'b0;
        repeat (3 * WIN) @(posedge clk);
        abort_after(0, w);
        t0 = cyc;
        wait_done(t1);
        check_len(t1 - t0, DLO, "R2 fallback to level");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule